// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. It steps the analog front end through a repeating measurement cycle of four phases: offset cancellation (auto-zero), input integration, reference deintegration and integrator discharge (integrator zero). For each phase it drives one registered switch-group enable, and only one enable is active at a time. All timing is counted on an internal timebase that ticks once every four input clocks.

An 8-bit load value L sets the auto-zero and integrate phases to the same length, (256 − L) × 256 ticks. During deintegration the block counts ticks until the comparator input changes from the level it had when integration ended. That count is the magnitude of the result. The comparator level at the end of integration is the sign. If no crossing arrives within twice the integrate count, the result saturates and an overrange flag is set. Each finished conversion loads the output register, gives a one-cycle valid pulse and stays visible until the next conversion finishes. An end-of-conversion output is low exactly while the sequencer sits in auto-zero, so it works as a data-ready indication.

A reset input holds the sequencer in auto-zero. A rising edge on the read/write line latches a new load value and restarts the cycle from auto-zero.

Top module: `dslope_seq`

## Requirements
- R1: Auto-zero and integrate each last exactly (256 − L) × 1024 clocks, where L is the latched load value. The timing is counted from the restart edge or from the last reset cycle.
- R2: Exactly one of the four phase enables is high in every cycle. The phases run in the order auto-zero, integrate, deintegrate, integrator zero, and then auto-zero again. Only reset or a load strobe breaks this order, and both go to auto-zero.
- R3: sign_o takes the comparator level sampled on the last timebase tick of integrate (1 = comparator high). It is presented together with the result.
- R4: Deintegrate ends on the first tick where the comparator differs from the captured sign. If that is the k-th tick of deintegrate, result_o = k − 1, ovr_o = 0, and deintegrate lasted 4k clocks. When a crossing and the count limit fall on the same tick, the crossing wins.
- R5: If no crossing occurs within 2 × (256 − L) × 256 ticks, deintegrate ends after 8 × (256 − L) × 256 clocks. In that case ovr_o = 1 and result_o is all ones (131071 at the default width).
- R6: Integrator zero lasts exactly 1024 clocks (256 ticks).
- R7: While rst_i is high the sequencer stays in auto-zero, and the result, sign, overrange and valid outputs read 0. The load value returns to 255, so after release auto-zero lasts 1024 clocks. Asserting reset mid-conversion forces auto-zero in the next cycle.
- R8: eoc_o is 0 in every cycle the auto-zero enable is high and 1 in every other cycle.
- R9: valid_o pulses high for exactly one cycle, in the first cycle of integrator zero after a deintegrate. result_o, sign_o and ovr_o change only in that cycle and hold their values otherwise.
- R10: A 0-to-1 transition of rw_i latches load_i and restarts the cycle from auto-zero with fresh timing. A conversion abandoned this way produces no valid pulse and leaves the held result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Active-high hold in auto-zero, synchronous |
| cmp_i | input | 1 | Zero-crossing comparator output |
| rw_i | input | 1 | Read/write line; its rising edge is the load strobe |
| load_i | input | 8 | Load value latched on the strobe |
| az_en_o | output | 1 | Auto-zero switch enable |
| int_en_o | output | 1 | Input integrate switch enable |
| dint_en_o | output | 1 | Reference deintegrate switch enable |
| iz_en_o | output | 1 | Integrator zero switch enable |
| result_o | output | 17 | Held conversion magnitude |
| sign_o | output | 1 | Held polarity, 1 = comparator was high |
| ovr_o | output | 1 | Held overrange flag |
| eoc_o | output | 1 | End of conversion, low during auto-zero |
| valid_o | output | 1 | One-cycle pulse when a new result is loaded |

## Verification
The checker watches on every cycle that exactly one phase enable is high and that each phase is followed only by itself, its successor or auto-zero. It also checks that a valid pulse follows only a deintegrate and lasts one cycle, that the held result moves only with that pulse, that an overrange result is saturated, and that reset forces auto-zero. Phase lengths in clocks, the exact count returned for a given crossing tick, the sign capture, the tie between a crossing and the count limit, and the effect of a mid-conversion strobe are shown only by the bench scenarios. These scenarios time the comparator against the enables.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    // One-hot phase encoding; the bit of each phase drives its switch group.
    typedef enum logic [3:0] {
        PH_AZ   = 4'b0001,
        PH_INT  = 4'b0010,
        PH_DINT = 4'b0100,
        PH_IZ   = 4'b1000
    } phase_e;

endpackage

// File: rtl/dslope_timebase.sv
module dslope_timebase #(
    parameter int DIV_W = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic tick_o
);

    logic [DIV_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + DIV_W'(1);
        if (restart_i) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // One tick per 2**DIV_W clocks, on the last prescaler state.
    assign tick_o = &pre_q;

endmodule

// File: rtl/dslope_phase_ctl.sv
module dslope_phase_ctl
    import dslope_pkg::*;
#(
    parameter int LOAD_W   = 8,
    parameter int SUB_W    = 8,
    parameter int IZ_TICKS = 256,
    parameter int LOAD_RST = 255,
    localparam int CNT_W   = LOAD_W + SUB_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              cmp_i,
    input  logic              rw_i,
    input  logic [LOAD_W-1:0] load_i,
    output phase_e            phase_o,
    output logic              restart_o,
    output logic              fin_o,
    output logic              fin_ovr_o,
    output logic              fin_sign_o,
    output logic [CNT_W-1:0]  fin_cnt_o
);

    localparam logic [CNT_W-1:0] IZ_LAST = CNT_W'(IZ_TICKS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [LOAD_W-1:0] load;
        logic              sign;
        logic              rw;
    } st_t;

    localparam st_t ST_RST = '{
        phase: PH_AZ,
        cnt:   '0,
        load:  LOAD_W'(LOAD_RST),
        sign:  1'b0,
        rw:    1'b1
    };

    st_t              st_d, st_q;
    logic             strobe;
    logic [CNT_W-1:0] ph_last;
    logic [CNT_W-1:0] dint_last;
    logic [CNT_W-1:0] cnt_inc;

    // (256-L)*256-1 and twice that plus one, built from the inverted load value.
    assign ph_last   = {1'b0, ~st_q.load, {SUB_W{1'b1}}};
    assign dint_last = {~st_q.load, {SUB_W{1'b1}}, 1'b1};
    assign cnt_inc   = st_q.cnt + CNT_W'(1);

    always_comb begin
        st_d      = st_q;
        st_d.rw   = rw_i;
        strobe    = rw_i & ~st_q.rw;
        fin_o     = 1'b0;
        fin_ovr_o = 1'b0;
        if (strobe) begin
            st_d.load  = load_i;
            st_d.phase = PH_AZ;
            st_d.cnt   = '0;
        end else if (tick_i) begin
            st_d.cnt = cnt_inc;
            unique case (st_q.phase)
                PH_AZ: begin
                    if (st_q.cnt == ph_last) begin
                        st_d.phase = PH_INT;
                        st_d.cnt   = '0;
                    end
                end
                PH_INT: begin
                    if (st_q.cnt == ph_last) begin
                        st_d.phase = PH_DINT;
                        st_d.cnt   = '0;
                        st_d.sign  = cmp_i;
                    end
                end
                PH_DINT: begin
                    if (cmp_i != st_q.sign) begin
                        fin_o      = 1'b1;
                        st_d.phase = PH_IZ;
                        st_d.cnt   = '0;
                    end else if (st_q.cnt == dint_last) begin
                        fin_o      = 1'b1;
                        fin_ovr_o  = 1'b1;
                        st_d.phase = PH_IZ;
                        st_d.cnt   = '0;
                    end
                end
                PH_IZ: begin
                    if (st_q.cnt == IZ_LAST) begin
                        st_d.phase = PH_AZ;
                        st_d.cnt   = '0;
                    end
                end
                default: begin
                    st_d.phase = PH_AZ;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o    = st_q.phase;
    assign restart_o  = strobe;
    assign fin_sign_o = st_q.sign;
    assign fin_cnt_o  = st_q.cnt;

endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
    parameter int RES_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             fin_i,
    input  logic             ovr_i,
    input  logic             sign_i,
    input  logic [RES_W-1:0] cnt_i,
    output logic [RES_W-1:0] result_o,
    output logic             sign_o,
    output logic             ovr_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             sign;
        logic             ovr;
        logic             valid;
    } res_t;

    res_t rs_d, rs_q;

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = fin_i;
        if (fin_i) begin
            rs_d.res  = ovr_i ? '1 : cnt_i;
            rs_d.sign = sign_i;
            rs_d.ovr  = ovr_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign result_o = rs_q.res;
    assign sign_o   = rs_q.sign;
    assign ovr_o    = rs_q.ovr;
    assign valid_o  = rs_q.valid;

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int LOAD_W   = 8,
    parameter int SUB_W    = 8,
    parameter int DIV_W    = 2,
    parameter int IZ_TICKS = 256,
    parameter int LOAD_RST = 255,
    localparam int RES_W   = LOAD_W + SUB_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmp_i,
    input  logic              rw_i,
    input  logic [LOAD_W-1:0] load_i,
    output logic              az_en_o,
    output logic              int_en_o,
    output logic              dint_en_o,
    output logic              iz_en_o,
    output logic [RES_W-1:0]  result_o,
    output logic              sign_o,
    output logic              ovr_o,
    output logic              eoc_o,
    output logic              valid_o
);

    phase_e           phase;
    logic             tick;
    logic             restart;
    logic             fin;
    logic             fin_ovr;
    logic             fin_sign;
    logic [RES_W-1:0] fin_cnt;

    dslope_timebase #(.DIV_W(DIV_W)) u_tb (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart),
        .tick_o    (tick)
    );

    dslope_phase_ctl #(
        .LOAD_W   (LOAD_W),
        .SUB_W    (SUB_W),
        .IZ_TICKS (IZ_TICKS),
        .LOAD_RST (LOAD_RST)
    ) u_ctl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick),
        .cmp_i      (cmp_i),
        .rw_i       (rw_i),
        .load_i     (load_i),
        .phase_o    (phase),
        .restart_o  (restart),
        .fin_o      (fin),
        .fin_ovr_o  (fin_ovr),
        .fin_sign_o (fin_sign),
        .fin_cnt_o  (fin_cnt)
    );

    dslope_result #(.RES_W(RES_W)) u_res (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .fin_i    (fin),
        .ovr_i    (fin_ovr),
        .sign_i   (fin_sign),
        .cnt_i    (fin_cnt),
        .result_o (result_o),
        .sign_o   (sign_o),
        .ovr_o    (ovr_o),
        .valid_o  (valid_o)
    );

    assign az_en_o   = (phase == PH_AZ);
    assign int_en_o  = (phase == PH_INT);
    assign dint_en_o = (phase == PH_DINT);
    assign iz_en_o   = (phase == PH_IZ);
    assign eoc_o     = ~az_en_o;

endmodule

module dslope_seq_chk #(
    parameter int RES_W = 17
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             az_en_o,
    input logic             int_en_o,
    input logic             dint_en_o,
    input logic             iz_en_o,
    input logic [RES_W-1:0] result_o,
    input logic             ovr_o,
    input logic             valid_o
);

    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk_i) begin
        rst_seen_q <= rst_i;
    end

    always @(posedge clk_i) begin
        if (rst_seen_q) begin
            AST_RST_FORCES_AZ: assert (az_en_o); // R7
        end
    end

    AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({az_en_o, int_en_o, dint_en_o, iz_en_o}) == 1); // R2

    AST_AZ_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        az_en_o |=> (az_en_o || int_en_o)); // R2

    AST_INT_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        int_en_o |=> (int_en_o || dint_en_o || az_en_o)); // R2

    AST_DINT_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        dint_en_o |=> (dint_en_o || iz_en_o || az_en_o)); // R2

    AST_IZ_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        iz_en_o |=> (iz_en_o || az_en_o)); // R2

    AST_VALID_AFTER_DINT: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (iz_en_o && $past(dint_en_o))); // R9

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o); // R9

    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(result_o)); // R9

    AST_OVR_SATURATED: assert property (@(posedge clk_i) disable iff (rst_i)
        ovr_o |-> (result_o == {RES_W{1'b1}})); // R5

endmodule

bind dslope_seq dslope_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .az_en_o   (az_en_o),
    .int_en_o  (int_en_o),
    .dint_en_o (dint_en_o),
    .iz_en_o   (iz_en_o),
    .result_o  (result_o),
    .ovr_o     (ovr_o),
    .valid_o   (valid_o)
);

// File: tb/sim_dslope_seq.sv
`timescale 1ns/1ps
module sim_dslope_seq;

    typedef struct packed {
        logic [7:0]  ld;
        logic        sg;
        logic [15:0] m;
        logic [16:0] ex;
        logic        ov;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd255, 1'b1, 16'd10,  17'd9,      1'b0},
        '{8'd255, 1'b0, 16'd100, 17'd99,     1'b0},
        '{8'd255, 1'b1, 16'd1,   17'd0,      1'b0},
        '{8'd255, 1'b1, 16'd512, 17'd511,    1'b0},
        '{8'd255, 1'b1, 16'd0,   17'h1FFFF,  1'b1},
        '{8'd254, 1'b0, 16'd600, 17'd599,    1'b0},
        '{8'd254, 1'b0, 16'd0,   17'h1FFFF,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp = 1'b0;
    logic        rw  = 1'b1;
    logic [7:0]  load = 8'd0;
    logic        az_en, int_en, dint_en, iz_en;
    logic [16:0] result;
    logic        sign, ovr, eoc, valid;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dslope_seq u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .cmp_i     (cmp),
        .rw_i      (rw),
        .load_i    (load),
        .az_en_o   (az_en),
        .int_en_o  (int_en),
        .dint_en_o (dint_en),
        .iz_en_o   (iz_en),
        .result_o  (result),
        .sign_o    (sign),
        .ovr_o     (ovr),
        .eoc_o     (eoc),
        .valid_o   (valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n4, c, d, e, extra, exp_d, bad_eoc;
        n4 = (256 - int'(v.ld)) * 1024;
        @(negedge clk);
        rw = 1'b0; load = v.ld; cmp = v.sg;
        @(negedge clk);
        rw = 1'b1;
        @(negedge clk);
        c = 0; bad_eoc = 0;
        while (az_en) begin
            if (eoc !== 1'b0) bad_eoc++;
            c++;
            @(negedge clk);
        end
        chk(c == n4, "R1 auto-zero length", c, n4);
        chk(bad_eoc == 0, "R8 eoc low in auto-zero", bad_eoc, 0);
        chk(int_en && eoc, "R2 integrate follows auto-zero", int_en, 1);
        c = 0; bad_eoc = 0;
        while (int_en) begin
            if (eoc !== 1'b1) bad_eoc++;
            c++;
            @(negedge clk);
        end
        chk(c == n4, "R1 integrate length", c, n4);
        chk(bad_eoc == 0, "R8 eoc high in integrate", bad_eoc, 0);
        chk(dint_en, "R2 deintegrate follows integrate", dint_en, 1);
        d = 0;
        while (dint_en) begin
            if (v.m != 0 && d == 4 * int'(v.m) - 1) cmp = ~v.sg;
            d++;
            @(negedge clk);
        end
        exp_d = (v.m != 0) ? 4 * int'(v.m) : 2 * n4;
        if (v.m != 0) chk(d == exp_d, "R4 deintegrate length", d, exp_d);
        else          chk(d == exp_d, "R5 overrange deintegrate length", d, exp_d);
        chk(valid && iz_en, "R9 valid at start of integrator zero", valid, 1);
        chk(result == v.ex, "R4 result count", int'(result), int'(v.ex));
        chk(sign == v.sg, "R3 captured sign", sign, v.sg);
        chk(ovr == v.ov, "R5 overrange flag", ovr, v.ov);
        e = 0; extra = 0;
        while (iz_en) begin
            if (e != 0 && valid) extra++;
            e++;
            @(negedge clk);
        end
        chk(e == 1024, "R6 integrator zero length", e, 1024);
        chk(extra == 0, "R9 single valid pulse", extra, 0);
        chk(az_en && !eoc, "R2 wraps to auto-zero", az_en, 1);
        chk(result == v.ex, "R9 result held", int'(result), int'(v.ex));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c, bad, vcnt;
        repeat (5) @(negedge clk);
        chk(az_en && !int_en && !dint_en && !iz_en, "R7 reset phase", az_en, 1);
        chk(eoc == 1'b0, "R8 eoc in reset", eoc, 0);
        chk(result == 0 && !sign && !ovr && !valid, "R7 reset outputs", int'(result), 0);

        bad = 0;
        for (int i = 0; i < 3000; i++) begin
            if (!az_en) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R7 held in auto-zero during reset", bad, 0);

        rst = 1'b0;
        c = 0;
        while (az_en) begin
            c++;
            @(negedge clk);
        end
        chk(c == 1024, "R7 auto-zero length after release", c, 1024);
        chk(int_en && eoc, "R8 eoc high after auto-zero", eoc, 1);

        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(az_en && !int_en, "R7 reset mid-integrate", az_en, 1);
        chk(eoc == 1'b0, "R8 eoc on forced auto-zero", eoc, 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k]);
        end

        // Restart in the middle of a deintegrate.
        @(negedge clk);
        rw = 1'b0; load = 8'd255; cmp = 1'b1;
        @(negedge clk);
        rw = 1'b1;
        while (!dint_en) @(negedge clk);
        repeat (20) @(negedge clk);
        rw = 1'b0; load = 8'd254;
        @(negedge clk);
        rw = 1'b1;
        @(negedge clk);
        c = 0; vcnt = 0;
        while (az_en) begin
            if (valid) vcnt++;
            c++;
            @(negedge clk);
        end
        chk(c == 2048, "R10 new load value timing", c, 2048);
        chk(vcnt == 0, "R10 no valid from abandoned conversion", vcnt, 0);
        chk(result == 17'h1FFFF && ovr, "R10 held result unchanged", int'(result), 17'h1FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule